// File: doc/BRIEF.md
# Three-Operand Raster-Op Block Transfer Engine

This block moves a rectangle of pixels into video memory. Each result pixel is a bitwise Boolean function of three inputs: a source pixel, the destination pixel already in memory, and a pattern pixel taken from an 8×8 tile. The 8-bit operation code is the truth table of that function, so all 256 three-input functions can be selected. The source comes either from a host stream, one word per pixel over a valid/ready handshake, or from a second region of video memory. Pixels are packed at 8 or 16 bits.

Software writes the geometry, the operation code, the format and the pattern tile through a small register write port, then writes the start register. The engine walks the rectangle one pixel at a time. For each pixel it reads the source if the source is in memory, reads the destination if the operation code needs it, and then writes the result. The memory port is word wide and uses byte enables for 8-bit pixels. A memory-to-memory copy between overlapping regions is walked backwards when that is needed to keep unread source pixels intact. Starts are honoured only while the graphics-mode input is high.

Top module: `bitblt_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `host_ready` are low.
- R2: A write to configuration offset 7 starts a transfer only when `gfx_mode` is high, the engine is idle and both the width and the height are nonzero. In any other case it is ignored: `busy` stays low and no memory request follows.
- R3: For every bit i of a pixel, the result bit equals bit {P[i],S[i],D[i]} of the operation code, with P (pattern) as the most significant index bit and D (destination) as the least significant.
- R4: The pattern tile has 64 entries written at configuration offsets 64 + 8·ry + rx. A pixel at offset (x, y) inside the rectangle uses entry rx = x mod 8, ry = y mod 8. The low byte of the entry is used in 8-bit mode.
- R5: The pixel byte address is base + y·pitch + x·b, where b is 1 in 8-bit mode and 2 in 16-bit mode. The memory word address is the byte address shifted right by one. In 16-bit mode `mem_be` = 11. In 8-bit mode, byte-address bit 0 selects the lane: 0 gives bits 7:0 with `mem_be` = 01, and 1 gives bits 15:8 with `mem_be` = 10. The result byte is driven on both lanes.
- R6: With the host as source, exactly one host word is consumed per pixel when `host_valid` and `host_ready` are both high. In 8-bit mode only its low byte is used. No memory read is issued for the source.
- R7: With memory as source, each pixel is handled in this order: source read, then destination read (when needed), then result write. Every pixel of the rectangle is written exactly once.
- R8: Pixels are visited row by row from the top-left, x increasing fastest. A memory-to-memory transfer whose destination base is above the source base and below the end of the source region is instead visited from the bottom-right, x decreasing fastest and then y decreasing.
- R9: When the operation code does not depend on D (code bit 2k equals bit 2k+1 for k = 0..3), no destination read is issued.
- R10: In the cycle after the final write is granted, `busy` is low and `done` is high. `done` is high for exactly that one cycle.
- R11: A memory request that is not granted stays asserted, with the same address, write flag and byte enables, until it is granted.
- Configuration offsets: 0 source base, 1 destination base, 2 width in pixels, 3 height in rows, 4 source pitch in bytes, 5 destination pitch in bytes, 6 control. The control word holds the operation code in bits 7:0, 16-bit mode in bit 8 and host source in bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gfx_mode | input | 1 | Graphics mode active; starts are honoured only while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration offset (registers below 64, pattern tile at 64 and above) |
| cfg_wdata | input | AW | Configuration write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final write is granted |
| host_valid | input | 1 | Host word available |
| host_data | input | 16 | Host source word |
| host_ready | output | 1 | Engine accepts a host word this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW-1 | Memory word address |
| mem_be | output | 2 | Byte enables for writes |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Read data |

## Verification
A new start request can arrive in the same cycle as the grant of the final write, while `busy` is still high. The start must then be ignored, and the end-of-transfer pulse must still be raised. The bench sets this up by granting every request at once and driving the start register write in the very cycle it grants the last expected write. It judges the result three ways: `done` rises in the following cycle, `busy` stays low afterwards, and no further memory write appears against an empty scoreboard.

// File: rtl/bitblt_pkg.sv
package bitblt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_SRCW,
    ST_DST,
    ST_DSTW,
    ST_WR
  } blt_state_e;

  localparam logic [2:0] OFS_SRC   = 3'd0;
  localparam logic [2:0] OFS_DST   = 3'd1;
  localparam logic [2:0] OFS_WID   = 3'd2;
  localparam logic [2:0] OFS_HGT   = 3'd3;
  localparam logic [2:0] OFS_SPIT  = 3'd4;
  localparam logic [2:0] OFS_DPIT  = 3'd5;
  localparam logic [2:0] OFS_CTRL  = 3'd6;
  localparam logic [2:0] OFS_START = 3'd7;

  // True when the truth table changes with the destination operand.
  function automatic logic code_uses_dst(input logic [7:0] code);
    return (code & 8'h55) != ((code >> 1) & 8'h55);
  endfunction

  // Extract one pixel from a memory word.
  function automatic logic [15:0] pick_pix(input logic [15:0] word,
                                           input logic lane,
                                           input logic wide);
    if (wide) return word;
    return {8'h00, lane ? word[15:8] : word[7:0]};
  endfunction

endpackage

// File: rtl/blt_rop_unit.sv
module blt_rop_unit #(
  parameter int W = 16
) (
  input  logic [7:0]   code,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [W-1:0] res
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res[i] = code[{pat[i], src[i], dst[i]}];
  end
endmodule

// File: rtl/blt_pattern_ram.sv
module blt_pattern_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/blt_addr_calc.sv
module blt_addr_calc #(
  parameter int AW    = 16,
  parameter int DIM_W = 10
) (
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    pitch,
  input  logic [DIM_W-1:0] x,
  input  logic [DIM_W-1:0] y,
  input  logic             wide,
  output logic [AW-1:0]    addr
);
  logic [AW-1:0] row_off;
  logic [AW-1:0] xe;
  logic [AW-1:0] col_off;

  assign row_off = AW'(y) * pitch;
  assign xe      = AW'(x);
  assign col_off = wide ? {xe[AW-2:0], 1'b0} : xe;
  assign addr    = base + row_off + col_off;
endmodule

// File: rtl/bitblt_engine.sv
module bitblt_engine #(
  parameter int AW     = 16,
  parameter int DIM_W  = 10,
  parameter int CFG_AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gfx_mode,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic              busy,
  output logic              done,
  input  logic              host_valid,
  input  logic [15:0]       host_data,
  output logic              host_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-2:0]     mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata
);
  import bitblt_pkg::*;

  localparam int PIX_W   = 16;
  localparam int TILE    = 8;
  localparam int TILE_IW = $clog2(TILE);
  localparam int PAT_IW  = 2 * TILE_IW;

  logic [AW-1:0]    src_base, dst_base, src_pitch, dst_pitch;
  logic [DIM_W-1:0] width_r, height_r, w_m1, h_m1;
  logic [7:0]       code_r;
  logic             wide_r, hsrc_r;

  blt_state_e       state;
  logic [DIM_W-1:0] x_q, y_q;
  logic             rev_q, busy_q, done_q;
  logic [PIX_W-1:0] s_pix, d_pix, pat_q, rop_res;
  logic [AW-1:0]    src_addr, dst_addr, src_end;
  logic             need_d, last_px, start_ok, overlap, pat_we, reg_we;

  assign w_m1 = width_r - DIM_W'(1);
  assign h_m1 = height_r - DIM_W'(1);

  blt_addr_calc #(.AW(AW), .DIM_W(DIM_W)) u_src_ag (
    .base(src_base), .pitch(src_pitch), .x(x_q), .y(y_q),
    .wide(wide_r), .addr(src_addr));

  blt_addr_calc #(.AW(AW), .DIM_W(DIM_W)) u_dst_ag (
    .base(dst_base), .pitch(dst_pitch), .x(x_q), .y(y_q),
    .wide(wide_r), .addr(dst_addr));

  // First byte past the source region.
  blt_addr_calc #(.AW(AW), .DIM_W(DIM_W)) u_end_ag (
    .base(src_base), .pitch(src_pitch), .x(width_r), .y(h_m1),
    .wide(wide_r), .addr(src_end));

  assign pat_we = cfg_we && cfg_addr[CFG_AW-1];
  assign reg_we = cfg_we && !cfg_addr[CFG_AW-1];

  blt_pattern_ram #(.W(PIX_W), .DEPTH(TILE * TILE)) u_pat (
    .clk(clk), .we(pat_we), .waddr(cfg_addr[PAT_IW-1:0]),
    .wdata(cfg_wdata[PIX_W-1:0]),
    .raddr({y_q[TILE_IW-1:0], x_q[TILE_IW-1:0]}), .rdata(pat_q));

  blt_rop_unit #(.W(PIX_W)) u_rop (
    .code(code_r), .pat(pat_q), .src(s_pix), .dst(d_pix), .res(rop_res));

  assign need_d   = code_uses_dst(code_r);
  assign last_px  = rev_q ? (x_q == '0 && y_q == '0)
                          : (x_q == w_m1 && y_q == h_m1);
  assign start_ok = cfg_we && (cfg_addr == CFG_AW'(OFS_START)) && gfx_mode &&
                    !busy_q && (width_r != '0) && (height_r != '0);
  assign overlap  = !hsrc_r && (dst_base > src_base) && (dst_base < src_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rev_q     <= 1'b0;
      x_q       <= '0;
      y_q       <= '0;
      s_pix     <= '0;
      d_pix     <= '0;
      src_base  <= '0;
      dst_base  <= '0;
      src_pitch <= '0;
      dst_pitch <= '0;
      width_r   <= '0;
      height_r  <= '0;
      code_r    <= '0;
      wide_r    <= 1'b0;
      hsrc_r    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (reg_we) begin
        case (cfg_addr[2:0])
          OFS_SRC:  src_base  <= cfg_wdata;
          OFS_DST:  dst_base  <= cfg_wdata;
          OFS_WID:  width_r   <= cfg_wdata[DIM_W-1:0];
          OFS_HGT:  height_r  <= cfg_wdata[DIM_W-1:0];
          OFS_SPIT: src_pitch <= cfg_wdata;
          OFS_DPIT: dst_pitch <= cfg_wdata;
          OFS_CTRL: begin
            code_r <= cfg_wdata[7:0];
            wide_r <= cfg_wdata[8];
            hsrc_r <= cfg_wdata[9];
          end
          default: ;
        endcase
      end
      unique case (state)
        ST_IDLE: if (start_ok) begin
          rev_q  <= overlap;
          x_q    <= overlap ? w_m1 : '0;
          y_q    <= overlap ? h_m1 : '0;
          busy_q <= 1'b1;
          state  <= ST_SRC;
        end
        ST_SRC: begin
          if (hsrc_r) begin
            if (host_valid) begin
              s_pix <= wide_r ? host_data : {8'h00, host_data[7:0]};
              state <= need_d ? ST_DST : ST_WR;
            end
          end else if (mem_gnt) begin
            state <= ST_SRCW;
          end
        end
        ST_SRCW: if (mem_rvalid) begin
          s_pix <= pick_pix(mem_rdata, src_addr[0], wide_r);
          state <= need_d ? ST_DST : ST_WR;
        end
        ST_DST: if (mem_gnt) state <= ST_DSTW;
        ST_DSTW: if (mem_rvalid) begin
          d_pix <= pick_pix(mem_rdata, dst_addr[0], wide_r);
          state <= ST_WR;
        end
        ST_WR: if (mem_gnt) begin
          if (last_px) begin
            state  <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            state <= ST_SRC;
            if (!rev_q) begin
              if (x_q == w_m1) begin
                x_q <= '0;
                y_q <= y_q + DIM_W'(1);
              end else begin
                x_q <= x_q + DIM_W'(1);
              end
            end else begin
              if (x_q == '0) begin
                x_q <= w_m1;
                y_q <= y_q - DIM_W'(1);
              end else begin
                x_q <= x_q - DIM_W'(1);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign host_ready = (state == ST_SRC) && hsrc_r;
  assign mem_req    = ((state == ST_SRC) && !hsrc_r) || (state == ST_DST) ||
                      (state == ST_WR);
  assign mem_we     = (state == ST_WR);
  assign mem_addr   = (state == ST_SRC) ? src_addr[AW-1:1] : dst_addr[AW-1:1];
  assign mem_be     = wide_r ? 2'b11 : (dst_addr[0] ? 2'b10 : 2'b01);
  assign mem_wdata  = wide_r ? rop_res : {rop_res[7:0], rop_res[7:0]};

endmodule

// File: rtl/bitblt_engine_chk.sv
module bitblt_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          gfx_mode,
  input logic          host_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-2:0] mem_addr,
  input logic [1:0]    mem_be
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                           $stable(mem_be));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R6
  host_excl_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> busy && !mem_req);

  // R2
  gfx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && !gfx_mode |=> !busy);

  // R5
  lane_en_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> $onehot(mem_be) || mem_be == 2'b11);
endmodule

bind bitblt_engine bitblt_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .gfx_mode(gfx_mode),
  .host_ready(host_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_be(mem_be));

// File: tb/tb_bitblt_engine.sv
module tb_bitblt_engine;
  localparam int AW = 16;

  typedef struct packed {
    logic [14:0] a;
    logic [1:0]  be;
    logic [15:0] d;
  } wr_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gfx_mode = 1'b1;
  logic cfg_we_t = 1'b0;
  logic [6:0] cfg_addr_t = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic coin_fire = 1'b0;
  logic cfg_we;
  logic [6:0] cfg_addr;
  logic busy, done, host_ready, mem_req, mem_we;
  logic host_valid = 1'b0;
  logic [15:0] host_data = '0;
  logic [AW-2:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata;
  logic mem_gnt = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  assign cfg_we   = cfg_we_t | coin_fire;
  assign cfg_addr = coin_fire ? 7'd7 : cfg_addr_t;

  always #4 clk = ~clk;

  bitblt_engine #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .gfx_mode(gfx_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .busy(busy), .done(done),
    .host_valid(host_valid), .host_data(host_data), .host_ready(host_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata));

  int n_cmp = 0;
  int n_bad = 0;
  int cycle = 0;
  int reads_seen = 0;
  int writes_seen = 0;
  logic [15:0] mem_m [256];
  logic [15:0] sh [256];
  logic [15:0] pat [64];
  wr_t exp_q [$];
  logic [15:0] host_q [$];
  logic [7:0] lfsr = 8'h5B;
  bit rd_pend = 0, host_fire = 0, done_due = 0, gnt_all = 0, coin_arm = 0;
  logic [15:0] rd_word = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Memory model, host driver and write monitor, all acting at the falling edge.
  always @(negedge clk) begin
    wr_t e;
    logic [15:0] m;
    cycle++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (cycle == 150000) begin
      chk(0, "R10", "watchdog expired", 32'(busy), 32'd0);
      summary();
      $finish;
    end
    if (done_due) begin
      chk(done === 1'b1 && busy === 1'b0, "R10", "done/busy after last write",
          32'({done, busy}), 32'b10);
      done_due = 0;
    end else if (done === 1'b1) begin
      chk(0, "R10", "done outside end cycle", 32'(done), 32'd0);
    end
    mem_rvalid = 1'b0;
    if (rd_pend) begin
      mem_rvalid = 1'b1;
      mem_rdata  = rd_word;
      rd_pend    = 0;
    end
    if (host_fire) void'(host_q.pop_front());
    host_valid = (host_q.size() > 0) && (lfsr[1] | lfsr[6]);
    host_data  = host_valid ? host_q[0] : 16'h0000;
    host_fire  = host_valid && host_ready;
    coin_fire  = 1'b0;
    mem_gnt    = mem_req && (gnt_all || lfsr[0] || lfsr[3]);
    if (mem_gnt) begin
      if (mem_we) begin
        writes_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R7", "unexpected write", 32'(mem_addr), 32'hFFFF);
        end else begin
          e = exp_q.pop_front();
          m = {{8{e.be[1]}}, {8{e.be[0]}}};
          chk(mem_addr == e.a, "R8", "write address/order", 32'(mem_addr), 32'(e.a));
          chk(mem_be == e.be, "R5", "byte enables", 32'(mem_be), 32'(e.be));
          chk((mem_wdata & m) == (e.d & m), "R3", "result data",
              32'(mem_wdata & m), 32'(e.d & m));
          if (exp_q.size() == 0) begin
            done_due = 1;
            if (coin_arm) begin
              coin_fire = 1'b1;
              coin_arm  = 0;
            end
          end
        end
        if (mem_be[0]) mem_m[mem_addr[7:0]][7:0]  = mem_wdata[7:0];
        if (mem_be[1]) mem_m[mem_addr[7:0]][15:8] = mem_wdata[15:8];
      end else begin
        reads_seen++;
        rd_pend = 1;
        rd_word = mem_m[mem_addr[7:0]];
      end
    end
  end

  task automatic cfg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we_t   = 1'b1;
    cfg_addr_t = 7'(a);
    cfg_wdata  = AW'(d);
    @(negedge clk);
    cfg_we_t = 1'b0;
  endtask

  function automatic logic [15:0] rop_eval(input logic [7:0] c,
      input logic [15:0] p, input logic [15:0] s, input logic [15:0] d);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = c[{p[i], s[i], d[i]}];
    return r;
  endfunction

  function automatic bit code_needs_d(input logic [7:0] c);
    for (int k = 0; k < 8; k += 2) if (c[k] != c[k+1]) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] rd_pix(input int a, input bit wide);
    logic [15:0] w;
    w = sh[(a >> 1) & 255];
    if (wide) return w;
    return (a % 2 == 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic run_job(input string name, input int src, input int dst,
                         input int w, input int h, input int sp, input int dp,
                         input logic [7:0] code, input bit wide, input bit hsrc,
                         input bit coin);
    int bpb, exp_reads, wr_before;
    bit rev;
    cfg_wr(0, src); cfg_wr(1, dst); cfg_wr(2, w); cfg_wr(3, h);
    cfg_wr(4, sp);  cfg_wr(5, dp);
    cfg_wr(6, {22'd0, hsrc, wide, code});
    bpb = wide ? 2 : 1;
    rev = !hsrc && dst > src && dst < src + (h - 1) * sp + w * bpb;
    for (int i = 0; i < 256; i++) sh[i] = mem_m[i];
    for (int k = 0; k < w * h; k++) begin
      int x, y, sa, da;
      logic [15:0] s, d, p, r, hv;
      wr_t e;
      x  = rev ? w - 1 - k % w : k % w;
      y  = rev ? h - 1 - k / w : k / w;
      sa = src + y * sp + x * bpb;
      da = dst + y * dp + x * bpb;
      if (hsrc) begin
        hv = 16'(32'hB000 + k * 263);
        host_q.push_back(hv);
        s = wide ? hv : {8'h00, hv[7:0]};
      end else begin
        s = rd_pix(sa, wide);
      end
      d = rd_pix(da, wide);
      p = pat[(y % 8) * 8 + x % 8];
      r = rop_eval(code, p, s, d);
      e.a = 15'(da >> 1);
      if (wide) begin
        e.be = 2'b11;
        e.d  = r;
        sh[(da >> 1) & 255] = r;
      end else begin
        e.be = (da % 2 == 1) ? 2'b10 : 2'b01;
        e.d  = {r[7:0], r[7:0]};
        if (da % 2 == 1) sh[(da >> 1) & 255][15:8] = r[7:0];
        else             sh[(da >> 1) & 255][7:0]  = r[7:0];
      end
      exp_q.push_back(e);
    end
    exp_reads  = (hsrc ? 0 : w * h) + (code_needs_d(code) ? w * h : 0);
    reads_seen = 0;
    gnt_all    = coin;
    coin_arm   = coin;
    cfg_wr(7, 0);
    chk(busy === 1'b1, "R2", {name, " start accepted"}, 32'(busy), 32'd1);
    for (int i = 0; i < 20000 && (exp_q.size() != 0 || busy); i++) @(negedge clk);
    wr_before = writes_seen;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R7", {name, " writes outstanding"}, 32'(exp_q.size()), 32'd0);
    chk(reads_seen == exp_reads, "R9", {name, " memory reads (R6 for host source)"},
        32'(reads_seen), 32'(exp_reads));
    chk(host_q.size() == 0, "R6", {name, " host words left"}, 32'(host_q.size()), 32'd0);
    if (coin) begin
      chk(busy === 1'b0 && writes_seen == wr_before, "R2",
          {name, " start coinciding with last write ignored"},
          32'(writes_seen - wr_before), 32'd0);
    end
    gnt_all = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 16'(i * 40503) ^ 16'h5A5A;
    for (int i = 0; i < 64; i++)  pat[i]   = 16'(i * 3869) ^ 16'h3C96;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && host_ready === 1'b0,
        "R1", "reset outputs", 32'({busy, done, mem_req, host_ready}), 32'd0);
    rst = 1'b0;
    // R4 pattern tile load
    for (int i = 0; i < 64; i++) cfg_wr(64 + i, int'(pat[i]));

    // R2: start with graphics mode off is ignored
    cfg_wr(0, 16'h10); cfg_wr(1, 16'h60); cfg_wr(2, 2); cfg_wr(3, 2);
    cfg_wr(4, 8); cfg_wr(5, 8); cfg_wr(6, 16'h00CC);
    gfx_mode = 1'b0;
    reads_seen = 0;
    cfg_wr(7, 0);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0 && reads_seen == 0 && writes_seen == 0, "R2",
        "start ignored outside graphics mode", 32'(busy), 32'd0);
    gfx_mode = 1'b1;

    // R2: zero width start is ignored
    cfg_wr(2, 0);
    cfg_wr(7, 0);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0 && reads_seen == 0 && writes_seen == 0, "R2",
        "zero-width start ignored", 32'(busy), 32'd0);

    // R6 R9: host source, 16-bit, pure source copy
    run_job("host16_copy", 0, 16'h40, 3, 2, 0, 16, 8'hCC, 1, 1, 0);
    // R5 R6: host source, 8-bit, odd destination, S xor D
    run_job("host8_xor", 0, 16'h81, 5, 2, 0, 12, 8'h66, 0, 1, 0);
    // R4 R9: pattern fill over more than one tile, no destination read
    run_job("mem16_pattern", 0, 16'h100, 10, 9, 20, 20, 8'hF0, 1, 0, 0);
    // R3 R7: three-operand function, 8-bit memory to memory
    run_job("mem8_pxsxd", 16'h10, 16'h61, 4, 3, 8, 10, 8'h96, 0, 0, 0);
    // R8: overlapping copy, destination above source, walked backwards
    run_job("mem8_overlap", 16'h30, 16'h32, 6, 2, 8, 8, 8'hCC, 0, 0, 0);
    // R10 R2: start coinciding with the final write grant
    run_job("mem16_coincide", 16'hC0, 16'hA0, 3, 2, 8, 8, 8'h5A, 1, 0, 1);

    summary();
    $finish;
  end
endmodule